// File: doc/BRIEF.md
# Vector Element Extract-Insert Unit

This unit takes an old destination vector and a source vector, picks one element out of the source and writes it into one element slot of the destination. Every other destination element comes through untouched. The vectors are 256 bits wide and are handled as two independent 128-bit lanes. Each lane does the same copy at the same relative positions and never reaches across into the other lane. Elements may be bytes, halfwords, words or doublewords.

An 8-bit immediate holds both positions, one per nibble. The high nibble is the slot to overwrite and the low nibble is the element to fetch. Each nibble is trimmed to the number of elements a lane holds at the chosen size. A mode input picks one of two forms. The wide form updates both lanes. The narrow form updates only the low lane and passes the upper 128 bits of the old destination through unchanged. The result is registered and appears one clock after the request, together with a one-cycle done strobe. The caller handles instruction decode and register-file writeback.

Top module: `vec_extract_insert`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `out_valid` is 0 and `out_data` is all zeros.
- R2: A request sampled with `in_valid` high produces `out_valid` high on the next clock edge. In any cycle after an edge where `in_valid` was low, `out_valid` is 0.
- R3: `in_size` selects the element width. The encoding is 2'b00 for 64-bit, 2'b01 for 32-bit, 2'b10 for 16-bit and 2'b11 for 8-bit. Element k of a lane occupies lane bits starting at k times the width.
- R4: The insert slot is `in_imm[7:4]` and the extract element is `in_imm[3:0]`. Both are ANDed with a mask of 0xF for 8-bit, 0x7 for 16-bit, 0x3 for 32-bit and 0x1 for 64-bit elements, so any higher index bits have no effect.
- R5: In an updated lane, the element at the insert slot takes the source element at the extract position of the same lane. Every other element of that lane equals the old destination element.
- R6: When `in_wide` is 1, the low lane (bits 127:0) and the high lane (bits 255:128) are both updated using the same slot indices. Each lane reads only its own source lane.
- R7: When `in_wide` is 0, the low lane is updated and bits 255:128 of `out_data` equal bits 255:128 of `in_dst`.
- R8: After a cycle with `in_valid` low, `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_wide | input | 1 | 1 updates both 128-bit lanes, 0 updates the low lane only |
| in_size | input | 2 | Element width code (00=64, 01=32, 10=16, 11=8 bits) |
| in_imm | input | 8 | Packed indices: insert slot high nibble, extract element low nibble |
| in_dst | input | 256 | Old destination vector |
| in_src | input | 256 | Source vector |
| out_valid | output | 1 | Done strobe, one clock after the request |
| out_data | output | 256 | Registered result vector |

## Verification
In the wide form, the two lane insertions happen in the same cycle from the same indices. The bench fills each source lane with distinct byte values and sends requests that hit the last element of a lane (for example an immediate of 0xFF at byte size). If the lane offset were wrong, lane 1 would pick up lane-0 bytes and the mismatch would show in the high half of the result. Back-to-back requests also put a new load in the same cycle as the previous result's done strobe. The per-cycle reference model checks both the strobe and the data on every such step.

// File: rtl/vxi_pkg.sv
package vxi_pkg;
  typedef enum logic [1:0] {
    SZ_DWORD = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_HALF  = 2'b10,
    SZ_BYTE  = 2'b11
  } elem_size_e;

  // log2 of the element width in bytes: the size code runs in reverse.
  function automatic logic [1:0] width_log2(input logic [1:0] code);
    return ~code;
  endfunction
endpackage

// File: rtl/vxi_index_decode.sv
module vxi_index_decode #(
  parameter int IDX_W = 4
) (
  input  logic [1:0]         size_code,
  input  logic [2*IDX_W-1:0] imm,
  output logic [1:0]         log2w,
  output logic [IDX_W-1:0]   ins_idx,
  output logic [IDX_W-1:0]   ext_idx
);
  logic [IDX_W-1:0] cnt_mask;

  always_comb begin
    log2w    = vxi_pkg::width_log2(size_code);
    cnt_mask = {IDX_W{1'b1}} >> log2w;
    ins_idx  = imm[2*IDX_W-1:IDX_W] & cnt_mask;
    ext_idx  = imm[IDX_W-1:0] & cnt_mask;
  end
endmodule

// File: rtl/vxi_lane.sv
module vxi_lane #(
  parameter int LANE_BYTES = 16,
  parameter int IDX_W      = 4
) (
  input  logic                    en,
  input  logic [1:0]              log2w,
  input  logic [IDX_W-1:0]        ins_idx,
  input  logic [IDX_W-1:0]        ext_idx,
  input  logic [LANE_BYTES*8-1:0] dst,
  input  logic [LANE_BYTES*8-1:0] src,
  output logic [LANE_BYTES*8-1:0] res
);
  logic [7:0] src_b [LANE_BYTES];

  for (genvar s = 0; s < LANE_BYTES; s++) begin : g_unpack
    assign src_b[s] = src[s*8 +: 8];
  end

  for (genvar b = 0; b < LANE_BYTES; b++) begin : g_byte
    logic [IDX_W-1:0] elem_no;
    logic [IDX_W-1:0] byte_off;
    logic [IDX_W-1:0] pick;
    logic             hit;

    always_comb begin
      elem_no  = IDX_W'(b) >> log2w;
      byte_off = IDX_W'(b) & ~({IDX_W{1'b1}} << log2w);
      pick     = (ext_idx << log2w) | byte_off;
      hit      = en && (elem_no == ins_idx);
      res[b*8 +: 8] = hit ? src_b[pick] : dst[b*8 +: 8];
    end
  end
endmodule

// File: rtl/vec_extract_insert.sv
module vec_extract_insert #(
  parameter int VEC_W  = 256,
  parameter int LANE_W = 128
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              in_valid,
  input  logic                              in_wide,
  input  logic [1:0]                        in_size,
  input  logic [2*$clog2(LANE_W/8)-1:0]     in_imm,
  input  logic [VEC_W-1:0]                  in_dst,
  input  logic [VEC_W-1:0]                  in_src,
  output logic                              out_valid,
  output logic [VEC_W-1:0]                  out_data
);
  localparam int LANE_BYTES = LANE_W / 8;
  localparam int LANES      = VEC_W / LANE_W;
  localparam int IDX_W      = $clog2(LANE_BYTES);

  logic [1:0]       log2w;
  logic [IDX_W-1:0] ins_idx;
  logic [IDX_W-1:0] ext_idx;
  logic [VEC_W-1:0] next_data;

  vxi_index_decode #(.IDX_W(IDX_W)) u_dec (
    .size_code (in_size),
    .imm       (in_imm),
    .log2w     (log2w),
    .ins_idx   (ins_idx),
    .ext_idx   (ext_idx)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic lane_en;
    assign lane_en = (l == 0) || in_wide;

    vxi_lane #(.LANE_BYTES(LANE_BYTES), .IDX_W(IDX_W)) u_lane (
      .en      (lane_en),
      .log2w   (log2w),
      .ins_idx (ins_idx),
      .ext_idx (ext_idx),
      .dst     (in_dst[l*LANE_W +: LANE_W]),
      .src     (in_src[l*LANE_W +: LANE_W]),
      .res     (next_data[l*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= next_data;
    end
  end
endmodule

// File: rtl/vec_extract_insert_chk.sv
module vec_extract_insert_chk #(
  parameter int VEC_W  = 256,
  parameter int LANE_W = 128
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          in_valid,
  input logic                          in_wide,
  input logic [1:0]                    in_size,
  input logic [2*$clog2(LANE_W/8)-1:0] in_imm,
  input logic [VEC_W-1:0]              in_dst,
  input logic [VEC_W-1:0]              in_src,
  input logic                          out_valid,
  input logic [VEC_W-1:0]              out_data
);
  localparam int IDX_W  = $clog2(LANE_W / 8);
  localparam int DW_CNT = LANE_W / 64;

  logic             byte_q;
  logic [IDX_W-1:0] bins_q;
  logic [7:0]       bval_q;
  logic             dw_q;
  logic [IDX_W-1:0] dkeep_q;
  logic [63:0]      dval_q;
  logic [IDX_W-1:0] dins;

  assign dins = in_imm[2*IDX_W-1:IDX_W] & IDX_W'(DW_CNT - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q  <= 1'b0;
      dw_q    <= 1'b0;
      bins_q  <= '0;
      bval_q  <= '0;
      dkeep_q <= '0;
      dval_q  <= '0;
    end else begin
      byte_q  <= in_valid && (in_size == 2'b11);
      bins_q  <= in_imm[2*IDX_W-1:IDX_W];
      bval_q  <= in_src[in_imm[IDX_W-1:0]*8 +: 8];
      dw_q    <= in_valid && (in_size == 2'b00);
      dkeep_q <= dins ^ IDX_W'(1);
      dval_q  <= in_dst[(dins ^ IDX_W'(1))*64 +: 64];
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!out_valid && out_data == '0));

  // R2
  done_follows_chk: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);

  // R2
  done_drop_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(out_data));

  // R7
  upper_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_wide) |=> out_data[VEC_W-1:LANE_W] == $past(in_dst[VEC_W-1:LANE_W]));

  // R4
  byte_insert_chk: assert property (@(posedge clk) disable iff (rst)
    byte_q |-> out_data[bins_q*8 +: 8] == bval_q);

  // R5
  dword_keep_chk: assert property (@(posedge clk) disable iff (rst)
    dw_q |-> out_data[dkeep_q*64 +: 64] == dval_q);
endmodule

bind vec_extract_insert vec_extract_insert_chk #(.VEC_W(VEC_W), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/vec_extract_insert_tb.sv
module vec_extract_insert_tb;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         in_wide;
  logic [1:0]   in_size;
  logic [7:0]   in_imm;
  logic [255:0] in_dst;
  logic [255:0] in_src;
  logic         out_valid;
  logic [255:0] out_data;

  int checks = 0;
  int fails  = 0;
  logic [255:0] last_out;

  always #4 clk = ~clk;

  vec_extract_insert u_dut (.*);

  function automatic logic [255:0] model(input logic wide, input logic [1:0] sz,
                                         input logic [7:0] imm,
                                         input logic [255:0] d, input logic [255:0] s);
    logic [255:0] r = d;
    int w = 8 >> sz;
    int m = 16 / w;
    int ins = int'(imm[7:4]) % m;
    int ext = int'(imm[3:0]) % m;
    int nl = wide ? 2 : 1;
    for (int l = 0; l < nl; l++)
      for (int k = 0; k < w; k++)
        r[(l*16 + ins*w + k)*8 +: 8] = s[(l*16 + ext*w + k)*8 +: 8];
    return r;
  endfunction

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input string req, input logic wide, input logic [1:0] sz,
                    input logic [7:0] imm, input logic [255:0] d, input logic [255:0] s);
    logic [255:0] exp = model(wide, sz, imm, d, s);
    in_valid = 1'b1; in_wide = wide; in_size = sz; in_imm = imm; in_dst = d; in_src = s;
    @(negedge clk);
    check({req, " done strobe (R2)"}, 256'(out_valid), 256'(1));
    check(req, out_data, exp);
    last_out = out_data;
  endtask

  task automatic idle(input logic [255:0] noise);
    in_valid = 1'b0; in_dst = noise; in_src = ~noise; in_imm = noise[7:0];
    @(negedge clk);
    check("R2 strobe low when idle", 256'(out_valid), 256'(0));
    check("R8 result held when idle", out_data, last_out);
  endtask

  function automatic logic [255:0] ramp(input logic [7:0] base);
    logic [255:0] v;
    for (int i = 0; i < 32; i++) v[i*8 +: 8] = base + 8'(i);
    return v;
  endfunction

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_wide = 1'b0; in_size = 2'b00;
    in_imm = '0; in_dst = '0; in_src = '0;
    repeat (3) @(negedge clk);
    check("R1 reset strobe", 256'(out_valid), 256'(0));
    check("R1 reset data", out_data, '0);
    rst = 1'b0;
    last_out = '0;
    @(negedge clk);

    // R3 R5 byte size, wide, with lane-end indices (R6)
    op("R6 byte wide last slot", 1'b1, 2'b11, 8'hFF, ramp(8'h00), ramp(8'h80));
    op("R6 byte wide slot 0 from 5", 1'b1, 2'b11, 8'h05, ramp(8'h10), ramp(8'hA0));
    idle(ramp(8'h55));
    // R3 halfword, word, doubleword
    op("R3 half wide", 1'b1, 2'b10, 8'h36, ramp(8'h20), ramp(8'hC0));
    op("R3 word wide", 1'b1, 2'b01, 8'h21, ramp(8'h30), ramp(8'hD0));
    op("R3 dword wide", 1'b1, 2'b00, 8'h10, ramp(8'h40), ramp(8'hE0));
    // R4 upper index bits masked
    op("R4 half mask", 1'b1, 2'b10, 8'hF9, ramp(8'h01), ramp(8'h90));
    op("R4 word mask", 1'b1, 2'b01, 8'hE7, ramp(8'h02), ramp(8'h91));
    op("R4 dword mask", 1'b1, 2'b00, 8'hFE, ramp(8'h03), ramp(8'h92));
    // R7 narrow form
    op("R7 byte narrow", 1'b0, 2'b11, 8'hF0, ramp(8'h04), ramp(8'h93));
    op("R7 dword narrow", 1'b0, 2'b00, 8'h01, ramp(8'h05), ramp(8'h94));
    idle('1);
    idle('0);

    for (int n = 0; n < 300; n++) begin
      logic [255:0] d = {8{$urandom}};
      logic [255:0] s = {8{$urandom}};
      op("R5 random", 1'($urandom), 2'($urandom), 8'($urandom), d, s);
      if (n % 7 == 0) idle({8{$urandom}});
    end

    idle('0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule